// File: doc/BRIEF.md
# Multi-Mode Iterative CORDIC Engine

This block evaluates elementary functions with shift-and-add micro-rotations on three signed fixed-point operands x, y and z. One datapath serves circular, linear and hyperbolic coordinates, each in rotation mode or vectoring mode. A 6-bit opcode is captured together with a start strobe. The engine then runs one micro-rotation per clock until the pass is over, and raises a one-cycle done pulse. The final x, y and z stay on the outputs until the next operation is accepted.

Operands are two's complement numbers of `W` bits with `F` fractional bits (defaults 48 and 40). Each pass has `ITERS` micro-rotations (default 53). In step k the engine computes x' = x − μ·d·(y>>>i), y' = y + d·(x>>>i) and z' = z − d·e_i. The shift by i is done by a combinational barrel shifter. Coordinate values are μ=+1 with e_i=atan(2^-i) for circular, μ=0 with e_i=2^-i for linear, and μ=−1 with e_i=atanh(2^-i) for hyperbolic.

A compound tangent operation chains two passes. A circular rotation pass leaves cosine and sine in x and y. z is then cleared, and a linear vectoring pass divides y by x into z. The caller removes the gain by preloading the starting vector, for example x = 1/K and y = 0 for cosine and sine.

Top module: `cordic_engine`

## Requirements
- R1: After reset, done_o is 0 and x_o, y_o and z_o are all zero.
- R2: Opcode fields: op_i[1:0] selects the system (00 circular, 01 linear, 10 hyperbolic, 11 acts as circular), op_i[2] selects vectoring (1) or rotation (0), op_i[3]=1 selects the compound tangent and overrides bits [2:0], and op_i[5:4] have no effect.
- R3: Circular rotation gives x = K(x0·cos z0 − y0·sin z0) and y = K(y0·cos z0 + x0·sin z0), with K the product of sqrt(1+2^-2i) over the pass, for |z0| ≤ π/2. Here d = +1 when z ≥ 0 and −1 otherwise.
- R4: Circular vectoring, with x0 > 0, gives x = K·sqrt(x0²+y0²) and z = z0 + atan(y0/x0). Here d = +1 when y < 0 and −1 otherwise.
- R5: Linear rotation leaves x exactly unchanged in every step and gives y = y0 + x0·z0 for |z0| < 2.
- R6: Linear vectoring, with x0 > 0 and |y0/x0| < 2, gives z = z0 + y0/x0 and leaves x unchanged.
- R7: Hyperbolic shift indices start at 1, and indices 4, 13 and 40 are each used twice in a row. Rotation gives x = Kh(x0·cosh z0 + y0·sinh z0) and y = Kh(y0·cosh z0 + x0·sinh z0), with Kh the product of sqrt(1−2^-2i) over that schedule.
- R8: Hyperbolic vectoring, with x0 > |y0|, gives z = z0 + atanh(y0/x0) and x = Kh·sqrt(x0² − y0²).
- R9: The tangent operation with x0 = 1/K, y0 = 0 gives x = cos z0 and z = tan z0 for |tan z0| < 2, and completes in 2·ITERS cycles.
- R10: A single-pass operation raises done_o exactly ITERS clock cycles after the edge that accepted start_i, and done_o lasts one cycle.
- R11: A start_i pulse while an operation is running has no effect on that operation's results or timing.
- R12: A start_i in the cycle where done_o is high is accepted. Without a new start, the outputs hold their final values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a new operation; accepted when idle |
| op_i | input | 6 | Operation code (see R2) |
| x_i | input | W | Initial x, signed fixed point |
| y_i | input | W | Initial y, signed fixed point |
| z_i | input | W | Initial z (angle or multiplier), signed fixed point |
| x_o | output | W | Final x |
| y_o | output | W | Final y |
| z_o | output | W | Final z |
| done_o | output | 1 | One-cycle pulse when the last pass ends |

## Verification
Two events can fall in the same clock: a new start request and the done pulse of the operation that is finishing. The bench waits until it sees done_o high, raises start_i in that same cycle with a different opcode and operands, and then requires that the new operation is accepted. It also requires the second result to arrive exactly ITERS cycles later with the second function's value. A related collision, a start request in the middle of a pass, is provoked ten cycles in. It is judged by comparing the first operation's result and latency with undisturbed values.

// File: rtl/cordic_pkg.sv
package cordic_pkg;

   typedef enum logic [1:0] {
      SYS_CIRC = 2'd0,
      SYS_LIN  = 2'd1,
      SYS_HYP  = 2'd2
   } cord_sys_e;

   // Elementary angle for one shift index, scaled by 2**frac.
   function automatic logic signed [63:0] angle_const(input cord_sys_e sys,
                                                      input int i,
                                                      input int frac);
      real t;
      real r;
      t = 2.0 ** (-i);
      case (sys)
         SYS_CIRC: r = $atan(t);
         SYS_HYP : r = (i == 0) ? 0.0 : $atanh(t);
         default : r = t;
      endcase
      return longint'(r * (2.0 ** frac));
   endfunction

   // Hyperbolic indices that are executed twice: 4, 13, 40, 121, ...
   function automatic logic hyp_repeat(input int i);
      int   k;
      logic hit;
      k   = 4;
      hit = 1'b0;
      for (int n = 0; n < 8; n++) begin
         if (i == k) hit = 1'b1;
         k = 3 * k + 1;
      end
      return hit;
   endfunction

endpackage

// File: rtl/cordic_bshift.sv
module cordic_bshift #(
   parameter int W          = 48,
   parameter int SW         = 6,
   parameter bit LOG_STAGES = 1'b1
) (
   input  logic signed [W-1:0] d_i,
   input  logic [SW-1:0]       amt_i,
   output logic signed [W-1:0] d_o
);

   if (LOG_STAGES) begin : g_log
      // One mux rank per amount bit, shift by 2**s in rank s.
      logic signed [W-1:0] lv [SW+1];
      assign lv[0] = d_i;
      for (genvar s = 0; s < SW; s++) begin : g_rank
         assign lv[s+1] = amt_i[s] ? (lv[s] >>> (2 ** s)) : lv[s];
      end
      assign d_o = lv[SW];
   end else begin : g_flat
      assign d_o = d_i >>> amt_i;
   end

endmodule

// File: rtl/cordic_angle_rom.sv
module cordic_angle_rom
   import cordic_pkg::*;
#(
   parameter int W     = 48,
   parameter int F     = 40,
   parameter int ITERS = 53,
   parameter int IW    = 6
) (
   input  cord_sys_e           sys_i,
   input  logic [IW-1:0]       idx_i,
   output logic signed [W-1:0] ang_o
);

   logic signed [W-1:0] tab_circ [ITERS];
   logic signed [W-1:0] tab_lin  [ITERS];
   logic signed [W-1:0] tab_hyp  [ITERS];

   for (genvar g = 0; g < ITERS; g++) begin : g_ent
      localparam logic signed [63:0] C_CIRC = angle_const(SYS_CIRC, g, F);
      localparam logic signed [63:0] C_LIN  = angle_const(SYS_LIN,  g, F);
      localparam logic signed [63:0] C_HYP  = angle_const(SYS_HYP,  g, F);
      assign tab_circ[g] = C_CIRC[W-1:0];
      assign tab_lin[g]  = C_LIN[W-1:0];
      assign tab_hyp[g]  = C_HYP[W-1:0];
   end

   always_comb begin
      ang_o = '0;
      if (int'(idx_i) < ITERS) begin
         case (sys_i)
            SYS_LIN: ang_o = tab_lin[idx_i];
            SYS_HYP: ang_o = tab_hyp[idx_i];
            default: ang_o = tab_circ[idx_i];
         endcase
      end
   end

endmodule

// File: rtl/cordic_ctrl.sv
module cordic_ctrl
   import cordic_pkg::*;
#(
   parameter int ITERS = 53,
   parameter int IW    = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [5:0]    op_i,
   output logic          load_o,
   output logic          step_o,
   output logic          zclr_o,
   output cord_sys_e     sys_o,
   output logic          vec_o,
   output logic [IW-1:0] idx_o,
   output logic          done_o
);

   localparam logic [IW-1:0] LAST_STEP = IW'(ITERS - 1);

   logic          busy_q;
   logic [IW-1:0] step_q;
   logic [IW-1:0] idx_q;
   logic          rep_q;
   cord_sys_e     sys_q;
   logic          vec_q;
   logic          tan_q;
   logic          done_q;

   cord_sys_e     op_sys;
   cord_sys_e     first_sys;
   logic          first_vec;
   logic          accept;
   logic          last;
   logic          unused_op;

   always_comb begin
      case (op_i[1:0])
         2'b01:   op_sys = SYS_LIN;
         2'b10:   op_sys = SYS_HYP;
         default: op_sys = SYS_CIRC;
      endcase
      first_sys = op_i[3] ? SYS_CIRC : op_sys;
      first_vec = op_i[3] ? 1'b0 : op_i[2];
   end

   assign unused_op = ^op_i[5:4];
   assign accept    = start_i && !busy_q;
   assign last      = busy_q && (step_q == LAST_STEP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         step_q <= '0;
         idx_q  <= '0;
         rep_q  <= 1'b0;
         sys_q  <= SYS_CIRC;
         vec_q  <= 1'b0;
         tan_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            busy_q <= 1'b1;
            step_q <= '0;
            idx_q  <= (first_sys == SYS_HYP) ? IW'(1) : '0;
            rep_q  <= 1'b0;
            sys_q  <= first_sys;
            vec_q  <= first_vec;
            tan_q  <= op_i[3];
         end else if (busy_q) begin
            if (last) begin
               if (tan_q) begin
                  // chain: linear vectoring divides y by x
                  tan_q  <= 1'b0;
                  sys_q  <= SYS_LIN;
                  vec_q  <= 1'b1;
                  step_q <= '0;
                  idx_q  <= '0;
                  rep_q  <= 1'b0;
               end else begin
                  busy_q <= 1'b0;
                  done_q <= 1'b1;
               end
            end else begin
               step_q <= step_q + IW'(1);
               if (sys_q == SYS_HYP && !rep_q && hyp_repeat(int'(idx_q))) begin
                  rep_q <= 1'b1;
               end else begin
                  idx_q <= idx_q + IW'(1);
                  rep_q <= 1'b0;
               end
            end
         end
      end
   end

   assign load_o = accept;
   assign step_o = busy_q;
   assign zclr_o = last && tan_q;
   assign sys_o  = sys_q;
   assign vec_o  = vec_q;
   assign idx_o  = idx_q;
   assign done_o = done_q;

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

   // R10
   step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (int'(step_q) < ITERS));

   // R7
   hyp_idx_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && sys_q == SYS_HYP) |-> (idx_q != '0));

   // R11
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !last) |=> (busy_q && $stable(sys_q) && $stable(vec_q)));

   // R12
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> !busy_q);

endmodule

// File: rtl/cordic_engine.sv
module cordic_engine
   import cordic_pkg::*;
#(
   parameter int W          = 48,
   parameter int F          = 40,
   parameter int ITERS      = 53,
   parameter bit LOG_SHIFT  = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic [5:0]          op_i,
   input  logic signed [W-1:0] x_i,
   input  logic signed [W-1:0] y_i,
   input  logic signed [W-1:0] z_i,
   output logic signed [W-1:0] x_o,
   output logic signed [W-1:0] y_o,
   output logic signed [W-1:0] z_o,
   output logic                done_o
);

   localparam int IW = (ITERS > 2) ? $clog2(ITERS) : 1;

   if (W < 8 || W > 64) begin : g_bad_w
      $error("cordic_engine: W must lie in 8..64");
   end
   if (F < 2 || F > W - 4) begin : g_bad_f
      $error("cordic_engine: F must leave at least 3 integer bits plus sign");
   end
   if (ITERS < 2) begin : g_bad_n
      $error("cordic_engine: ITERS must be at least 2");
   end

   logic                load;
   logic                step;
   logic                zclr;
   cord_sys_e           sys;
   logic                vec;
   logic [IW-1:0]       idx;

   logic signed [W-1:0] x_q, y_q, z_q;
   logic signed [W-1:0] x_sh, y_sh, ang;
   logic signed [W-1:0] x_n, y_n, z_n;
   logic                dpos;

   cordic_ctrl #(.ITERS(ITERS), .IW(IW)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .op_i    (op_i),
      .load_o  (load),
      .step_o  (step),
      .zclr_o  (zclr),
      .sys_o   (sys),
      .vec_o   (vec),
      .idx_o   (idx),
      .done_o  (done_o)
   );

   cordic_angle_rom #(.W(W), .F(F), .ITERS(ITERS), .IW(IW)) u_rom (
      .sys_i (sys),
      .idx_i (idx),
      .ang_o (ang)
   );

   cordic_bshift #(.W(W), .SW(IW), .LOG_STAGES(LOG_SHIFT)) u_shx (
      .d_i   (x_q),
      .amt_i (idx),
      .d_o   (x_sh)
   );

   cordic_bshift #(.W(W), .SW(IW), .LOG_STAGES(LOG_SHIFT)) u_shy (
      .d_i   (y_q),
      .amt_i (idx),
      .d_o   (y_sh)
   );

   // direction: vectoring steers y to zero, rotation steers z to zero
   assign dpos = vec ? y_q[W-1] : !z_q[W-1];

   always_comb begin
      case (sys)
         SYS_LIN: x_n = x_q;
         SYS_HYP: x_n = dpos ? (x_q + y_sh) : (x_q - y_sh);
         default: x_n = dpos ? (x_q - y_sh) : (x_q + y_sh);
      endcase
      y_n = dpos ? (y_q + x_sh) : (y_q - x_sh);
      z_n = dpos ? (z_q - ang)  : (z_q + ang);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x_q <= '0;
         y_q <= '0;
         z_q <= '0;
      end else if (load) begin
         x_q <= x_i;
         y_q <= y_i;
         z_q <= z_i;
      end else if (step) begin
         x_q <= x_n;
         y_q <= y_n;
         z_q <= zclr ? '0 : z_n;
      end
   end

   assign x_o = x_q;
   assign y_o = y_q;
   assign z_o = z_q;

   // R5
   lin_x_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && sys == SYS_LIN) |=> $stable(x_o));

   // R12
   hold_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start_i) |=> ($stable(x_o) && $stable(y_o) && $stable(z_o)));

endmodule

// File: tb/cordic_engine_tb.sv
module cordic_engine_tb;

   localparam int  W      = 48;
   localparam int  F      = 40;
   localparam int  ITERS  = 53;
   localparam time CLK_T  = 10ns;
   localparam real SC     = 2.0 ** F;
   localparam real TOL    = 1.0e-8;
   localparam real PI     = 3.14159265358979323846;

   localparam logic [5:0] OP_CROT = 6'b000000;
   localparam logic [5:0] OP_CVEC = 6'b000100;
   localparam logic [5:0] OP_LROT = 6'b000001;
   localparam logic [5:0] OP_LVEC = 6'b000101;
   localparam logic [5:0] OP_HROT = 6'b000010;
   localparam logic [5:0] OP_HVEC = 6'b000110;
   localparam logic [5:0] OP_TAN  = 6'b001000;
   localparam logic [5:0] OP_ODD  = 6'b110011;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                start = 1'b0;
   logic [5:0]          op = '0;
   logic signed [W-1:0] xi = '0, yi = '0, zi = '0;
   logic signed [W-1:0] xo, yo, zo;
   logic                done;

   int  checks = 0;
   int  errors = 0;
   real kc, kh;

   always #(CLK_T / 2) clk = ~clk;

   cordic_engine #(.W(W), .F(F), .ITERS(ITERS)) u_dut (
      .clk (clk), .rst_n (rst_n), .start_i (start), .op_i (op),
      .x_i (xi), .y_i (yi), .z_i (zi),
      .x_o (xo), .y_o (yo), .z_o (zo), .done_o (done)
   );

   function automatic logic signed [W-1:0] fx(input real r);
      return W'(longint'(r * SC));
   endfunction

   function automatic real fr(input logic signed [W-1:0] v);
      longint l;
      l = longint'(v);
      return real'(l) / SC;
   endfunction

   function automatic bit rep_idx(input int i);
      return (i == 4) || (i == 13) || (i == 40) || (i == 121);
   endfunction

   task automatic chk_r(input string tag, input real act, input real exp, input real tol);
      real diff;
      checks++;
      diff = act - exp;
      if (diff < 0.0) diff = -diff;
      if (diff > tol) begin
         errors++;
         $display("FAIL %s: actual %.12f expected %.12f", tag, act, exp);
      end
   endtask

   task automatic chk_i(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic launch(input logic [5:0] o, input real x, input real y, input real z);
      @(negedge clk);
      op = o; xi = fx(x); yi = fx(y); zi = fx(z);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done(output int cyc);
      cyc = 0;
      while (!done && cyc < 1000) begin
         @(negedge clk);
         cyc++;
      end
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL timeout: actual no done expected done");
      end
   endtask

   task automatic t_reset();
      chk_i("R1 done after reset", int'(done), 0);
      chk_r("R1 x after reset", fr(xo), 0.0, 0.0);
      chk_r("R1 y after reset", fr(yo), 0.0, 0.0);
      chk_r("R1 z after reset", fr(zo), 0.0, 0.0);
   endtask

   task automatic t_circ_rot(input real deg);
      int  cyc;
      real a;
      a = deg * PI / 180.0;
      launch(OP_CROT, 1.0 / kc, 0.0, a);
      wait_done(cyc);
      chk_i("R10 single pass latency", cyc, ITERS);
      chk_r("R3 cos", fr(xo), $cos(a), TOL);
      chk_r("R3 sin", fr(yo), $sin(a), TOL);
      @(negedge clk);
      chk_i("R10 done one cycle", int'(done), 0);
   endtask

   task automatic t_circ_vec();
      int cyc;
      launch(OP_CVEC, 0.6, 0.8, 0.1);
      wait_done(cyc);
      chk_r("R4 magnitude", fr(xo), kc * 1.0, TOL);
      chk_r("R4 angle", fr(zo), 0.1 + $atan2(0.8, 0.6), TOL);
   endtask

   task automatic t_lin_rot();
      int cyc;
      launch(OP_LROT, 1.5, 0.25, -0.75);
      wait_done(cyc);
      chk_r("R5 x unchanged", fr(xo), 1.5, 0.0);
      chk_r("R5 product", fr(yo), 0.25 - 1.125, TOL);
   endtask

   task automatic t_lin_vec();
      int cyc;
      launch(OP_LVEC, 2.0, -3.0, 0.25);
      wait_done(cyc);
      chk_r("R6 quotient", fr(zo), 0.25 - 1.5, TOL);
      chk_r("R6 x unchanged", fr(xo), 2.0, 0.0);
   endtask

   task automatic t_hyp_rot(input real z);
      int cyc;
      launch(OP_HROT, 1.0 / kh, 0.0, z);
      wait_done(cyc);
      chk_r("R7 cosh", fr(xo), $cosh(z), TOL);
      chk_r("R7 sinh", fr(yo), $sinh(z), TOL);
   endtask

   task automatic t_hyp_vec();
      int cyc;
      launch(OP_HVEC, 1.0, 0.5, 0.0);
      wait_done(cyc);
      chk_r("R8 atanh", fr(zo), $atanh(0.5), TOL);
      chk_r("R8 magnitude", fr(xo), kh * $sqrt(0.75), TOL);
   endtask

   task automatic t_tan(input real deg);
      int  cyc;
      real a;
      a = deg * PI / 180.0;
      launch(OP_TAN, 1.0 / kc, 0.0, a);
      wait_done(cyc);
      chk_i("R9 compound latency", cyc, 2 * ITERS);
      chk_r("R9 tan", fr(zo), $tan(a), TOL);
      chk_r("R9 cos kept", fr(xo), $cos(a), TOL);
   endtask

   task automatic t_odd_op();
      int  cyc;
      real a;
      a = 0.4;
      launch(OP_ODD, 1.0 / kc, 0.0, a);
      wait_done(cyc);
      chk_r("R2 code 11 acts circular", fr(yo), $sin(a), TOL);
      chk_r("R2 upper bits no effect", fr(xo), $cos(a), TOL);
   endtask

   task automatic t_busy_start();
      int  cyc;
      real a;
      a = PI / 6.0;
      launch(OP_CROT, 1.0 / kc, 0.0, a);
      repeat (10) @(negedge clk);
      op = OP_LROT; xi = fx(3.0); yi = fx(1.0); zi = fx(1.0);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done(cyc);
      chk_i("R11 latency undisturbed", cyc + 11, ITERS);
      chk_r("R11 result undisturbed", fr(xo), $cos(a), TOL);
      chk_r("R11 sin undisturbed", fr(yo), $sin(a), TOL);
   endtask

   task automatic t_back_to_back();
      int  cyc;
      real held;
      launch(OP_CROT, 1.0 / kc, 0.0, 0.3);
      wait_done(cyc);
      op = OP_HROT; xi = fx(1.0 / kh); yi = fx(0.0); zi = fx(-0.8);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done(cyc);
      chk_i("R12 start with done accepted", cyc, ITERS);
      chk_r("R12 second result", fr(xo), $cosh(-0.8), TOL);
      held = fr(yo);
      repeat (5) @(negedge clk);
      chk_r("R12 outputs hold", fr(yo), held, 0.0);
      chk_r("R12 held value", held, $sinh(-0.8), TOL);
   endtask

   initial begin
      int idx;
      bit rep;
      kc = 1.0;
      for (int i = 0; i < ITERS; i++) kc = kc * $sqrt(1.0 + 2.0 ** (-2 * i));
      kh  = 1.0;
      idx = 1;
      rep = 1'b0;
      for (int k = 0; k < ITERS; k++) begin
         kh = kh * $sqrt(1.0 - 2.0 ** (-2 * idx));
         if (rep_idx(idx) && !rep) rep = 1'b1;
         else begin idx++; rep = 1'b0; end
      end

      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_circ_rot(30.0);
      t_circ_rot(-75.0);
      t_circ_rot(89.0);
      t_circ_vec();
      t_lin_rot();
      t_lin_vec();
      t_hyp_rot(0.5);
      t_hyp_rot(-0.8);
      t_hyp_vec();
      t_tan(45.0);
      t_tan(-60.0);
      t_odd_op();
      t_busy_start();
      t_back_to_back();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(CLK_T * 150000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule